// File: doc/BRIEF.md
# DDR Read-Data Clock-Domain Crossing

This block takes read data that the DDR input registers have already split into a rising-edge word and a falling-edge word per core cycle, and carries it from the free-running read clock into the system clock. The read clock is a phase-shifted copy of the memory write clock. It is treated as unrelated to the system clock, so any skew between the two, up to one full period, is absorbed. The sampled data strobe is never used as a clock. It only marks the read-clock cycles that carry valid data.

The system side issues a read with a burst length counted in beats. One beat is a pair of words. The system side then sees `busy` until every word of the burst has been handed downstream. A read-active flag set in the system domain is synchronised into the read domain, and strobe-marked cycles are captured only while that synchronised flag is high. Each captured beat is stored as one entry in a small dual-clock FIFO with Gray-coded pointers. The system side reads that FIFO one word at a time, and `dout_vld` is the FIFO's not-empty state. Strobes with no read pending, and beats that find the FIFO full, are dropped and latched in sticky error flags visible in the system domain.

Top module: `ddr_rd_xfer`

## Requirements
- R1: While `arst_n` is low, and after it returns high until a read is issued, `busy`, `dout_vld`, `err_stray` and `err_ovf` are 0.
- R2: A `req` pulse with a nonzero `req_len` while `busy` is 0 sets `busy` at the next `sys_clk` edge. `req_len` counts beats, and each beat is two words.
- R3: The words of a beat leave in order: the rising-edge word (`cap_rise`), then the falling-edge word (`cap_fall`). Beats leave in the order they were captured, with no loss or duplication.
- R4: `dout_vld` is high exactly when stored words remain. A word is consumed at a `sys_clk` edge where `dout_vld` and `dout_ack` are both high. While it is not consumed, `dout` and `dout_vld` hold.
- R5: `busy` clears at the edge that consumes word number 2*`req_len`, and not before.
- R6: A `req` while `busy` is high has no effect on the burst in progress. A `req` with `req_len` equal to 0 leaves `busy` low.
- R7: A `stb_en` cycle while the synchronised read-active flag is low stores nothing and sets `err_stray`, which stays set until reset.
- R8: A beat that finds all FIFO entries (default 4 beats, 8 words) occupied is dropped whole, without disturbing stored words, and sets `err_ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rd_clk | input | 1 | Read-capture clock |
| cap_rise | input | DW | Rising-edge data word from the input registers |
| cap_fall | input | DW | Falling-edge data word from the input registers |
| stb_en | input | 1 | Sampled strobe presence, marks a data-carrying cycle |
| sys_clk | input | 1 | System clock |
| req | input | 1 | Read request pulse |
| req_len | input | LENW | Burst length in beats |
| busy | output | 1 | Read in progress |
| dout | output | DW | Head word toward downstream logic |
| dout_vld | output | 1 | `dout` holds a stored word |
| dout_ack | input | 1 | Downstream takes `dout` this cycle |
| err_stray | output | 1 | Sticky: strobe seen with no read active |
| err_ovf | output | 1 | Sticky: beat dropped on a full FIFO |

## Verification
The bench runs bursts from one to four beats with gaps between strobes and a stalling consumer. It compares every word against its position in the burst, so a design that swapped the rising and falling words, or re-read an entry, fails on the word value. A second request issued in the middle of a burst with a shorter length shows whether the length was reloaded: a design that reloaded it would drop `busy` before the last word. A six-beat read into a stalled consumer fills the FIFO. A design that wrapped the write pointer would overwrite the first beats and deliver wrong data or extra words. Strobes with no read pending must leave `dout_vld` low and raise only `err_stray`.

// File: rtl/ddr_rd_xfer.sv
module ddr_rd_xfer #(
  parameter int DW    = 16,
  parameter int PAIRS = 4,
  parameter int LENW  = 4
) (
  input  logic          arst_n,
  input  logic          rd_clk,
  input  logic [DW-1:0] cap_rise,
  input  logic [DW-1:0] cap_fall,
  input  logic          stb_en,
  input  logic          sys_clk,
  input  logic          req,
  input  logic [LENW-1:0] req_len,
  output logic          busy,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  input  logic          dout_ack,
  output logic          err_stray,
  output logic          err_ovf
);
  localparam int AW = $clog2(PAIRS);
  localparam int PW = AW + 1;

  logic [1:0] rrs, srs;
  logic rrst_n, srst_n;

  always_ff @(posedge rd_clk or negedge arst_n)
    if (!arst_n) rrs <= '0;
    else         rrs <= {rrs[0], 1'b1};
  always_ff @(posedge sys_clk or negedge arst_n)
    if (!arst_n) srs <= '0;
    else         srs <= {srs[0], 1'b1};
  assign rrst_n = rrs[1];
  assign srst_n = srs[1];

  logic [2*DW-1:0] mem [PAIRS];

  logic [PW-1:0] wptr, wgray, rg_s1, rg_s2;
  logic [PW-1:0] rptr, rgray, wg_s1, wg_s2;
  logic [PW-1:0] wptr_n, rptr_n;
  logic [1:0] act_s;
  logic act_rd, full, wr_en;
  logic stray_r, ovf_r;

  // read-clock domain
  assign act_rd = act_s[1];
  assign full   = (wgray ^ rg_s2) == {2'b11, {(PW-2){1'b0}}};
  assign wr_en  = stb_en && act_rd && !full;
  assign wptr_n = wptr + 1'b1;

  always_ff @(posedge rd_clk or negedge rrst_n)
    if (!rrst_n) begin
      act_s   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      wptr    <= '0;
      wgray   <= '0;
      stray_r <= 1'b0;
      ovf_r   <= 1'b0;
    end else begin
      act_s   <= {act_s[0], busy};
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      stray_r <= stray_r | (stb_en && !act_rd);
      ovf_r   <= ovf_r | (stb_en && act_rd && full);
      if (wr_en) begin
        wptr  <= wptr_n;
        wgray <= wptr_n ^ (wptr_n >> 1);
      end
    end

  always_ff @(posedge rd_clk)
    if (wr_en) mem[wptr[AW-1:0]] <= {cap_fall, cap_rise};

  // system-clock domain
  logic [LENW:0] left;
  logic [1:0] es_s, eo_s;
  logic half, pop;
  logic [2*DW-1:0] head;

  assign dout_vld  = (rgray != wg_s2);
  assign pop       = dout_vld && dout_ack;
  assign head      = mem[rptr[AW-1:0]];
  assign dout      = half ? head[2*DW-1:DW] : head[DW-1:0];
  assign rptr_n    = rptr + 1'b1;
  assign err_stray = es_s[1];
  assign err_ovf   = eo_s[1];

  always_ff @(posedge sys_clk or negedge srst_n)
    if (!srst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
      rptr  <= '0;
      rgray <= '0;
      half  <= 1'b0;
      busy  <= 1'b0;
      left  <= '0;
      es_s  <= '0;
      eo_s  <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      es_s  <= {es_s[0], stray_r};
      eo_s  <= {eo_s[0], ovf_r};
      if (pop) begin
        half <= !half;
        if (half) begin
          rptr  <= rptr_n;
          rgray <= rptr_n ^ (rptr_n >> 1);
        end
      end
      if (!busy) begin
        if (req && req_len != '0) begin
          busy <= 1'b1;
          left <= {req_len, 1'b0};
        end
      end else if (pop) begin
        left <= left - 1'b1;
        if (left == 1) busy <= 1'b0;
      end
    end
endmodule

// File: rtl/ddr_rd_xfer_chk.sv
module ddr_rd_xfer_chk #(
  parameter int DW   = 16,
  parameter int LENW = 4
) (
  input logic          sys_clk,
  input logic          rd_clk,
  input logic          srst_n,
  input logic          rrst_n,
  input logic          req,
  input logic [LENW-1:0] req_len,
  input logic          busy,
  input logic [DW-1:0] dout,
  input logic          dout_vld,
  input logic          dout_ack,
  input logic          stray_r,
  input logic          ovf_r,
  input logic          err_stray,
  input logic          err_ovf
);
  a_r1_reset_quiet: assert property (@(posedge sys_clk)
    !srst_n |-> !busy && !dout_vld && !err_stray && !err_ovf);

  a_r2_busy_origin: assert property (@(posedge sys_clk) disable iff (!srst_n)
    $rose(busy) |-> $past(req) && $past(req_len) != '0);

  a_r4_head_holds: assert property (@(posedge sys_clk) disable iff (!srst_n)
    dout_vld && !dout_ack |=> dout_vld && $stable(dout));

  a_r6_req_ignored: assert property (@(posedge sys_clk) disable iff (!srst_n)
    busy && req && !(dout_vld && dout_ack) |=> busy);

  a_r7_stray_sticky: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    stray_r |=> stray_r);

  a_r7_stray_out_sticky: assert property (@(posedge sys_clk) disable iff (!srst_n)
    err_stray |=> err_stray);

  a_r8_ovf_sticky: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    ovf_r |=> ovf_r);

  a_r8_ovf_out_sticky: assert property (@(posedge sys_clk) disable iff (!srst_n)
    err_ovf |=> err_ovf);
endmodule

bind ddr_rd_xfer ddr_rd_xfer_chk #(.DW(DW), .LENW(LENW)) chk_i (
  .sys_clk(sys_clk), .rd_clk(rd_clk), .srst_n(srst_n), .rrst_n(rrst_n),
  .req(req), .req_len(req_len), .busy(busy), .dout(dout),
  .dout_vld(dout_vld), .dout_ack(dout_ack), .stray_r(stray_r),
  .ovf_r(ovf_r), .err_stray(err_stray), .err_ovf(err_ovf)
);

// File: tb/ddr_rd_xfer_tb_top.sv
`timescale 1ns/1ps
module ddr_rd_xfer_tb_top;
  localparam int SYS_T   = 10;
  localparam int RD_T    = 10;
  localparam int RD_SKEW = 3;
  localparam int DW = 16;
  localparam int LENW = 4;
  localparam int NV = 5;
  localparam int V_BEATS [NV] = '{1, 2, 4, 3, 4};
  localparam int V_BASE  [NV] = '{16'h0100, 16'h0A20, 16'h3300, 16'h7F10, 16'hC0F0};
  localparam int V_STALL [NV] = '{0, 0, 1, 2, 0};
  localparam int V_GAP   [NV] = '{0, 1, 0, 2, 3};
  localparam int V_POKE  [NV] = '{0, 1, 0, 0, 0};

  logic sys_clk = 0, rd_clk = 0, arst_n = 0;
  logic [DW-1:0] cap_rise = '0, cap_fall = '0;
  logic stb_en = 0, req = 0, dout_ack = 0;
  logic [LENW-1:0] req_len = '0;
  logic busy, dout_vld, err_stray, err_ovf;
  logic [DW-1:0] dout;
  int n_chk = 0, n_fail = 0;

  ddr_rd_xfer #(.DW(DW), .PAIRS(4), .LENW(LENW)) dut_i (
    .arst_n(arst_n), .rd_clk(rd_clk), .cap_rise(cap_rise), .cap_fall(cap_fall),
    .stb_en(stb_en), .sys_clk(sys_clk), .req(req), .req_len(req_len),
    .busy(busy), .dout(dout), .dout_vld(dout_vld), .dout_ack(dout_ack),
    .err_stray(err_stray), .err_ovf(err_ovf));

  always #(SYS_T/2) sys_clk = ~sys_clk;
  initial begin
    #RD_SKEW;
    forever #(RD_T/2) rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive_beats(input int beats, input int base, input int gap);
    repeat (4) @(negedge rd_clk);
    for (int b = 0; b < beats; b++) begin
      cap_rise = DW'(base + 2*b);
      cap_fall = DW'(base + 2*b + 1);
      stb_en = 1;
      @(negedge rd_clk);
      stb_en = 0;
      repeat (gap) @(negedge rd_clk);
    end
  endtask

  task automatic consume(input int nwords, input int base, input int stall, input bit last_busy);
    int got = 0;
    int cyc = 0;
    while (got < nwords && cyc < 2000) begin
      @(negedge sys_clk);
      cyc++;
      dout_ack = (cyc % (stall + 1)) == 0;
      if (dout_vld && dout_ack) begin
        chk(dout == DW'(base + got), "R3 word order", dout, DW'(base + got));
        if (last_busy && got == nwords - 1) chk(busy == 1, "R5 busy before last word", busy, 1);
        got++;
      end
    end
    chk(got == nwords, "R4 word count", got, nwords);
    @(negedge sys_clk);
    dout_ack = 0;
  endtask

  task automatic run_burst(input int beats, input int base, input int stall, input int gap, input int poke);
    @(negedge sys_clk);
    req = 1; req_len = LENW'(beats);
    @(negedge sys_clk);
    req = poke != 0; req_len = 1;
    chk(busy == 1, "R2 busy on request", busy, 1);
    @(negedge sys_clk);
    req = 0;
    fork
      drive_beats(beats, base, gap);
      consume(2*beats, base, stall, 1);
    join
    chk(busy == 0, "R5 busy cleared after burst", busy, 0);
    repeat (6) @(negedge sys_clk);
    chk(dout_vld == 0, "R4 no extra words", dout_vld, 0);
    chk(busy == 0, "R6 no late restart", busy, 0);
  endtask

  initial begin
    #(SYS_T * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge sys_clk);
    chk(!busy && !dout_vld && !err_stray && !err_ovf, "R1 outputs in reset",
        {busy, dout_vld, err_stray, err_ovf}, 0);
    arst_n = 1;
    repeat (6) @(negedge sys_clk);
    chk(!busy && !dout_vld && !err_stray && !err_ovf, "R1 outputs after release",
        {busy, dout_vld, err_stray, err_ovf}, 0);

    for (int v = 0; v < NV; v++)
      run_burst(V_BEATS[v], V_BASE[v], V_STALL[v], V_GAP[v], V_POKE[v]);
    chk(err_stray == 0, "R7 no stray flag on normal reads", err_stray, 0);
    chk(err_ovf == 0, "R8 no overflow flag on normal reads", err_ovf, 0);

    // R6: zero length
    @(negedge sys_clk); req = 1; req_len = 0;
    @(negedge sys_clk); req = 0;
    chk(busy == 0, "R6 zero length ignored", busy, 0);

    // R7: strobes with no read pending
    seen = 0;
    fork
      begin
        @(negedge rd_clk); cap_rise = 16'hDEAD; cap_fall = 16'hBEEF; stb_en = 1;
        repeat (2) @(negedge rd_clk); stb_en = 0;
      end
      repeat (10) begin
        @(negedge sys_clk);
        if (dout_vld) seen = 1;
      end
    join
    chk(seen == 0, "R7 stray beat not stored", seen, 0);
    chk(err_stray == 1, "R7 stray flag set", err_stray, 1);
    repeat (5) @(negedge sys_clk);
    chk(err_stray == 1, "R7 stray flag sticky", err_stray, 1);

    // R8: overflow with stalled consumer
    @(negedge sys_clk); req = 1; req_len = 6;
    @(negedge sys_clk); req = 0;
    dout_ack = 0;
    drive_beats(6, 16'h5000, 0);
    repeat (8) @(negedge sys_clk);
    chk(err_ovf == 1, "R8 overflow flag set", err_ovf, 1);
    chk(busy == 1, "R8 read still open", busy, 1);
    consume(8, 16'h5000, 0, 0);
    repeat (6) @(negedge sys_clk);
    chk(dout_vld == 0, "R8 dropped beats absent", dout_vld, 0);
    chk(busy == 1, "R5 busy held for missing words", busy, 1);
    chk(err_ovf == 1, "R8 overflow flag sticky", err_ovf, 1);

    // R1: reset mid-operation
    @(negedge sys_clk); arst_n = 0;
    @(negedge sys_clk);
    chk(!busy && !dout_vld && !err_stray && !err_ovf, "R1 reset clears all",
        {busy, dout_vld, err_stray, err_ovf}, 0);
    arst_n = 1;
    repeat (6) @(negedge sys_clk);
    chk(!busy && !dout_vld && !err_stray && !err_ovf, "R1 quiet after second release",
        {busy, dout_vld, err_stray, err_ovf}, 0);

    run_burst(2, 16'h9000, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule